// File: doc/BRIEF.md
# Trace Port Integration Test Registers

This block sits beside a trace port unit and gives system integrators a way to prove the unit's wiring without running real trace traffic. A small 32-bit register bus (address, write enable, write data, read enable, read data) reaches a handful of test registers. Some of them drive the unit's four handshake outputs directly. Others return the levels on its trigger and flush inputs and on selected trace-bus slave inputs.

A single mode bit decides who owns the handshake outputs. While the bit is clear, each output passes its functional source straight through and the test registers only store values. While the bit is set, each output shows the last value software wrote for it. Every input that can be read back first passes through a two-flop synchroniser. The trace-data readback keeps only one edge bit of each byte lane: bit 0 of lane 0 and the top bit of every lane.

Top module: `trace_port_itest`

## Requirements
- R1: After a synchronous reset, the mode bit and all override bits are 0, rd_data is 0, and every handshake output follows its functional source.
- R2: Offset 0xF00 is read/write. Bit 0 is the mode bit. A read returns that bit in bit 0 and zero in every other bit.
- R3: While the mode bit is 0, trig_ack, flush_ack, tready and fvalid equal func_trig_ack, func_flush_ack, func_tready and func_fvalid.
- R4: While the mode bit is 1, trig_ack equals bit 0 and flush_ack equals bit 1 of the last write to offset 0xEE4.
- R5: While the mode bit is 1, tready equals bit 0 and fvalid equals bit 1 of the last write to offset 0xEF0.
- R6: A read of offset 0xEE8 returns the trigger input in bit 0 and the flush input in bit 1. All other bits are zero.
- R7: A read of offset 0xEEC returns tdata_in bits 0, 7, 15, 23 and 31 in result bits 0, 1, 2, 3 and 4. All other bits are zero.
- R8: A read of offset 0xEF4 returns the 7-bit source ID in bits 6:0. All other bits are zero.
- R9: A read of offset 0xEF8 returns the trace-valid input in bit 0, the flush-ready input in bit 1 and the byte count in bits 9:8. All other bits are zero.
- R10: A read of a write-only offset (0xEE4, 0xEF0) or of an unmapped offset returns zero. A write to a read-only or unmapped offset changes no output and no readback.
- R11: Read data appears on rd_data the cycle after the clock edge that samples rd_en, and rd_data is zero when no read was sampled. An input readback shows the pin level sampled two clock edges before the edge that samples the read.
- R12: Override bits keep their values while the mode bit is 0, and they take effect again as soon as the mode bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte offset of the register access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| func_trig_ack | input | 1 | Functional trigger acknowledge |
| func_flush_ack | input | 1 | Functional flush acknowledge |
| func_tready | input | 1 | Functional trace-ready |
| func_fvalid | input | 1 | Functional flush-valid |
| trig_in | input | 1 | Trigger request pin |
| flush_in | input | 1 | Flush request pin |
| tdata_in | input | 32 | Trace data slave pins |
| tvalid_in | input | 1 | Trace-valid slave pin |
| tid_in | input | 7 | Trace source ID pins |
| tbytes_in | input | 2 | Byte-count pins |
| fready_in | input | 1 | Flush-ready slave pin |
| trig_ack | output | 1 | Trigger acknowledge output |
| flush_ack | output | 1 | Flush acknowledge output |
| tready | output | 1 | Trace-ready output |
| fvalid | output | 1 | Flush-valid output |

## Verification
The readback registers are first exercised with pins that change on every cycle, which shows whether the two-cycle synchroniser latency is exact rather than off by one. A directed pattern that sets only the lane edge bits (0x80808081) and its complement (0x7F7F7F7E) separates a correct bit selection from a shifted or swapped one. The functional sources are randomised in both mode states, so an output that ignores the mode bit, or a stale override, shows up on the next cycle. Writes aimed at read-only and unmapped offsets, followed by reads, confirm that the stored state and the outputs are left alone.

// File: rtl/tpit_pkg.sv
package tpit_pkg;
    localparam int BUS_W   = 32;
    localparam int ADDR_W  = 12;
    localparam int TDATA_W = 32;
    localparam int LANES   = TDATA_W / 8;
    localparam int EDGE_N  = LANES + 1;
    localparam int ID_W    = 7;
    localparam int CNT_W   = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [BUS_W-1:0]  word_t;

    localparam addr_t OFF_ACK  = 12'hEE4;
    localparam addr_t OFF_HSIN = 12'hEE8;
    localparam addr_t OFF_DATA = 12'hEEC;
    localparam addr_t OFF_CTL2 = 12'hEF0;
    localparam addr_t OFF_ID   = 12'hEF4;
    localparam addr_t OFF_CTL0 = 12'hEF8;
    localparam addr_t OFF_MODE = 12'hF00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MODE,
        SEL_HSIN,
        SEL_DATA,
        SEL_ID,
        SEL_CTL0
    } rsel_e;

    typedef struct packed {
        logic flush;
        logic trig;
    } hs_t;

    typedef struct packed {
        logic fvalid;
        logic tready;
    } busctl_t;

    typedef struct packed {
        logic [EDGE_N-1:0] edge_bits;
        logic [ID_W-1:0]   id;
        logic [CNT_W-1:0]  bytes;
        logic              fready;
        logic              tvalid;
        hs_t               hs;
    } pins_t;

    // Data bit sampled for edge slot k: bit 0 for k = 0, else top bit of lane k-1
    function automatic int lane_bit(input int k);
        return (k == 0) ? 0 : (8 * k - 1);
    endfunction

    function automatic rsel_e decode_read(input addr_t a);
        case (a)
            OFF_MODE: return SEL_MODE;
            OFF_HSIN: return SEL_HSIN;
            OFF_DATA: return SEL_DATA;
            OFF_ID:   return SEL_ID;
            OFF_CTL0: return SEL_CTL0;
            default:  return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/tpit_sync.sv
module tpit_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/tpit_ctrl.sv
module tpit_ctrl
    import tpit_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_en,
    input  addr_t   addr,
    input  logic [1:0] wr_bits,
    input  hs_t     func_hs,
    input  busctl_t func_bus,
    output logic    mode_o,
    output hs_t     hs_out,
    output busctl_t bus_out
);
    logic    mode_q;
    hs_t     ack_q;
    busctl_t ctl2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            ack_q  <= '0;
            ctl2_q <= '0;
        end else if (wr_en) begin
            case (addr)
                OFF_MODE: mode_q <= wr_bits[0];
                OFF_ACK:  ack_q  <= hs_t'(wr_bits);
                OFF_CTL2: ctl2_q <= busctl_t'(wr_bits);
                default:  ;
            endcase
        end
    end

    always_comb begin
        if (mode_q) begin
            hs_out  = ack_q;
            bus_out = ctl2_q;
        end else begin
            hs_out  = func_hs;
            bus_out = func_bus;
        end
    end

    assign mode_o = mode_q;

    // R4
    ack_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_ACK && mode_q) |=> (hs_out == hs_t'($past(wr_bits))));

    // R5
    ctl2_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_CTL2 && mode_q) |=> (bus_out == busctl_t'($past(wr_bits))));
endmodule

// File: rtl/tpit_rdmux.sv
module tpit_rdmux
    import tpit_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_en,
    input  addr_t addr,
    input  logic  mode_i,
    input  pins_t pins_s,
    output word_t rd_data
);
    rsel_e sel;
    word_t word_d;
    word_t rd_q;

    assign sel = decode_read(addr);

    always_comb begin
        word_d = '0;
        case (sel)
            SEL_MODE: word_d[0] = mode_i;
            SEL_HSIN: word_d[1:0] = pins_s.hs;
            SEL_DATA: word_d[EDGE_N-1:0] = pins_s.edge_bits;
            SEL_ID:   word_d[ID_W-1:0] = pins_s.id;
            SEL_CTL0: begin
                word_d[0] = pins_s.tvalid;
                word_d[1] = pins_s.fready;
                word_d[8 +: CNT_W] = pins_s.bytes;
            end
            default:  word_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_q <= '0;
        else if (rd_en) rd_q <= word_d;
        else            rd_q <= '0;
    end

    assign rd_data = rd_q;

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (rd_data == '0));

    // R10
    wo_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (addr == OFF_ACK || addr == OFF_CTL2)) |=> (rd_data == '0));

    // R8
    id_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_ID) |=> (rd_data[BUS_W-1:ID_W] == '0));

    // R9
    ctl0_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == OFF_CTL0) |=> (rd_data[7:2] == '0 && rd_data[BUS_W-1:10] == '0));
endmodule

// File: rtl/trace_port_itest.sv
module trace_port_itest
    import tpit_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [11:0] addr,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    input  logic        rd_en,
    output logic [31:0] rd_data,
    input  logic        func_trig_ack,
    input  logic        func_flush_ack,
    input  logic        func_tready,
    input  logic        func_fvalid,
    input  logic        trig_in,
    input  logic        flush_in,
    input  logic [31:0] tdata_in,
    input  logic        tvalid_in,
    input  logic [6:0]  tid_in,
    input  logic [1:0]  tbytes_in,
    input  logic        fready_in,
    output logic        trig_ack,
    output logic        flush_ack,
    output logic        tready,
    output logic        fvalid
);
    localparam int PINS_W = $bits(pins_t);

    logic [EDGE_N-1:0] edge_raw;
    pins_t   pins_raw;
    pins_t   pins_s;
    logic [PINS_W-1:0] pins_sync;
    logic    mode;
    hs_t     hs_out;
    busctl_t bus_out;

    wire unused_wdata = ^wr_data[BUS_W-1:2];
    wire unused_tdata = ^tdata_in;

    for (genvar k = 0; k < EDGE_N; k++) begin : g_edge
        assign edge_raw[k] = tdata_in[lane_bit(k)];
    end

    assign pins_raw = '{edge_bits: edge_raw, id: tid_in, bytes: tbytes_in,
                        fready: fready_in, tvalid: tvalid_in,
                        hs: '{flush: flush_in, trig: trig_in}};

    tpit_sync #(.W(PINS_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_sync)
    );
    assign pins_s = pins_t'(pins_sync);

    tpit_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .addr     (addr),
        .wr_bits  (wr_data[1:0]),
        .func_hs  ('{flush: func_flush_ack, trig: func_trig_ack}),
        .func_bus ('{fvalid: func_fvalid, tready: func_tready}),
        .mode_o   (mode),
        .hs_out   (hs_out),
        .bus_out  (bus_out)
    );

    tpit_rdmux u_rd (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .addr    (addr),
        .mode_i  (mode),
        .pins_s  (pins_s),
        .rd_data (rd_data)
    );

    assign trig_ack  = hs_out.trig;
    assign flush_ack = hs_out.flush;
    assign tready    = bus_out.tready;
    assign fvalid    = bus_out.fvalid;
endmodule

// File: tb/sim_trace_port_itest.sv
`timescale 1ns/1ps
module sim_trace_port_itest;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        func_trig_ack = 0, func_flush_ack = 0, func_tready = 0, func_fvalid = 0;
    logic        trig_in = 0, flush_in = 0, tvalid_in = 0, fready_in = 0;
    logic [31:0] tdata_in = '0;
    logic [6:0]  tid_in = '0;
    logic [1:0]  tbytes_in = '0;
    logic        trig_ack, flush_ack, tready, fvalid;

    int checks = 0;
    int errors = 0;
    bit rnd_pins = 1'b0;
    bit rnd_func = 1'b1;

    always #2 clk = ~clk;

    trace_port_itest u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data),
        .func_trig_ack(func_trig_ack), .func_flush_ack(func_flush_ack),
        .func_tready(func_tready), .func_fvalid(func_fvalid),
        .trig_in(trig_in), .flush_in(flush_in), .tdata_in(tdata_in),
        .tvalid_in(tvalid_in), .tid_in(tid_in), .tbytes_in(tbytes_in),
        .fready_in(fready_in),
        .trig_ack(trig_ack), .flush_ack(flush_ack), .tready(tready), .fvalid(fvalid)
    );

    // Reference model state
    int    m_mode = 0, m_ack = 0, m_ctl2 = 0;
    int    m_rd = 0;
    string m_tag = "R1";
    int    h1 [4] = '{0, 0, 0, 0};
    int    h2 [4] = '{0, 0, 0, 0};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int now [4];
        now[0] = {30'd0, flush_in, trig_in};
        now[1] = {27'd0, tdata_in[31], tdata_in[23], tdata_in[15], tdata_in[7], tdata_in[0]};
        now[2] = {25'd0, tid_in};
        now[3] = {22'd0, tbytes_in, 6'd0, fready_in, tvalid_in};
        if (rst) begin
            m_mode = 0; m_ack = 0; m_ctl2 = 0; m_rd = 0; m_tag = "R1";
            foreach (h1[i]) begin h1[i] = 0; h2[i] = 0; end
        end else begin
            if (rd_en) begin
                case (addr)
                    12'hF00: begin m_rd = m_mode; m_tag = "R2"; end
                    12'hEE8: begin m_rd = h2[0]; m_tag = "R6"; end
                    12'hEEC: begin m_rd = h2[1]; m_tag = "R7"; end
                    12'hEF4: begin m_rd = h2[2]; m_tag = "R8"; end
                    12'hEF8: begin m_rd = h2[3]; m_tag = "R9"; end
                    default: begin m_rd = 0; m_tag = "R10"; end
                endcase
            end else begin
                m_rd = 0; m_tag = "R11";
            end
            if (wr_en) begin
                if (addr == 12'hF00) m_mode = wr_data[0];
                if (addr == 12'hEE4) m_ack = wr_data[1:0];
                if (addr == 12'hEF0) m_ctl2 = wr_data[1:0];
            end
            foreach (h1[i]) begin h2[i] = h1[i]; h1[i] = now[i]; end
        end
    end

    // Compare every cycle, away from the active edge
    always @(posedge clk) begin
        #1;
        chk(m_tag, rd_data, m_rd);
        if (m_mode == 0) begin
            chk("R3", {trig_ack, flush_ack, tready, fvalid},
                {func_trig_ack, func_flush_ack, func_tready, func_fvalid});
        end else begin
            chk("R4", {flush_ack, trig_ack}, m_ack[1:0]);
            chk("R5", {fvalid, tready}, m_ctl2[1:0]);
        end
    end

    // Background stimulus on pins and functional sources
    always @(negedge clk) begin
        if (rnd_func) {func_trig_ack, func_flush_ack, func_tready, func_fvalid} = 4'($urandom);
        if (rnd_pins) begin
            {trig_in, flush_in, tvalid_in, fready_in} = 4'($urandom);
            tdata_in  = $urandom;
            tid_in    = 7'($urandom);
            tbytes_in = 2'($urandom);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1; rd_en = 1'b0;
    endtask
    task automatic rd(input logic [11:0] a);
        @(negedge clk); addr = a; wr_en = 1'b0; rd_en = 1'b1;
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: state right after reset
        chk("R1", rd_data, 32'h0);
        chk("R1", {trig_ack, flush_ack, tready, fvalid},
            {func_trig_ack, func_flush_ack, func_tready, func_fvalid});
        rd(12'hF00); rd(12'hEE4);
        // R3 and R12: override bits stored while mode is 0
        wr(12'hEE4, 32'h3); wr(12'hEF0, 32'h3);
        idle(20);
        // R2: mode bit set with all-ones data, read back as 1
        wr(12'hF00, 32'hFFFF_FFFF);
        rd(12'hF00);
        idle(1);
        #1;
        chk("R12", {flush_ack, trig_ack, fvalid, tready}, 4'hF);
        // R4 / R5: several override patterns
        for (int v = 0; v < 4; v++) begin
            wr(12'hEE4, 32'(v)); idle(2);
            wr(12'hEF0, 32'(3 - v)); idle(2);
        end
        // R6..R9, R11: readbacks with pins changing every cycle
        rnd_pins = 1'b1;
        for (int i = 0; i < 40; i++) begin
            case (i % 4)
                0: rd(12'hEE8);
                1: rd(12'hEEC);
                2: rd(12'hEF4);
                default: rd(12'hEF8);
            endcase
        end
        rnd_pins = 1'b0;
        // R7: directed lane edge patterns
        @(negedge clk); tdata_in = 32'h8080_8081; idle(3);
        rd(12'hEEC); idle(1);
        @(negedge clk); tdata_in = 32'h7F7F_7F7E; idle(3);
        rd(12'hEEC); idle(1);
        // R10: writes to read-only / unmapped offsets, reads of write-only / unmapped
        wr(12'hEE8, 32'hFFFF_FFFF); wr(12'hEF8, 32'h0); wr(12'h000, 32'h0);
        wr(12'hEF4, 32'h0); wr(12'hEEC, 32'h0);
        rd(12'hEE4); rd(12'hEF0); rd(12'h004); rd(12'hFFC); rd(12'hF00);
        idle(2);
        // R3 then R12: leave and re-enter integration mode
        wr(12'hEE4, 32'h2); wr(12'hEF0, 32'h1);
        wr(12'hF00, 32'h0); idle(10);
        wr(12'hF00, 32'h1); idle(1);
        #1;
        chk("R12", {flush_ack, trig_ack, fvalid, tready}, 4'b1001);
        rd(12'hF00); idle(3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule